// File: doc/BRIEF.md
# Pad Contact Test Chain Controller

This block adds a board-level contact test to a peripheral chip that sits on the LPC bus. Each time the block reset input is released, it samples two bus pads: the frame strobe and bit 0 of the address/data lane. If both are low at that moment, the chip goes into chain test mode. If either is high, the chip goes back to, or stays in, functional mode. The decision then holds until the next release of that reset.

In chain test mode the functional core is cut off from the pads. Every pad becomes an input, and the core sees a parked all-zero input vector. The pad levels pass through a serial cascade of two-input XNOR stages. The last stage drives the pad that normally carries the serial transmit data, so a board tester can toggle one pad at a time and watch that single output. In functional mode all pads, including the transmit pad, pass straight through between the pads and the core.

Top module: `board_contact_chain`

## Requirements
- R1: After the synchronous power-on reset (`por_n` low at a clock edge), the block is in functional mode.
- R2: At the first rising `clk` edge where `rst_n` is high and the previous edge saw it low, the block enters chain test mode if pad bit FRAME_IDX (default 0) and pad bit LAD0_IDX (default 1) are both low. Pad outputs show the new mode right after that edge.
- R3: At such a reset-release edge, if either of those two pad bits is high, the block enters functional mode.
- R4: The mode changes at no other time. Changes on the two sampled pads while `rst_n` stays high have no effect, and holding `rst_n` low has no effect.
- R5: In chain test mode, `pad_oe` is all zeros and `pad_out` is all zeros.
- R6: In chain test mode, `core_in` is all zeros, whatever the pad levels are.
- R7: In chain test mode, changing any one bit of `pad_in` inverts `txd_pad`.
- R8: In chain test mode, `txd_pad` is the XOR of all N_PADS bits of `pad_in`, inverted when N_PADS is even. This follows from a cascade of N_PADS-1 XNOR stages that starts from bit 0.
- R9: In functional mode, `pad_oe` equals `core_oe`, `pad_out` equals `core_out`, `core_in` equals `pad_in`, and `txd_pad` equals `core_txd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Synchronous power-on reset, active low |
| rst_n | input | 1 | Bus reset, active low; its release edge latches the mode |
| pad_in | input | N_PADS | Levels seen at the chain-input pads |
| core_oe | input | N_PADS | Output enables requested by the functional core |
| core_out | input | N_PADS | Output values requested by the functional core |
| core_txd | input | 1 | Functional serial transmit data |
| core_in | output | N_PADS | Pad levels passed to the functional core |
| pad_oe | output | N_PADS | Output enables driven to the pads |
| pad_out | output | N_PADS | Output values driven to the pads |
| txd_pad | output | 1 | Transmit pad: carries core data or the chain result |

## Verification
The assertions sample the combinational chain and mux at rising clock edges. They assume that `pad_in` and `rst_n` settle well before each edge, so that a toggle check sees exactly one pad change between two edges. The bench keeps within this by changing pads and reset only on falling edges. During the pad walk it changes at most one pad per clock cycle, and it releases reset only after the two sampled pads have been set up.

// File: rtl/bct_pkg.sv
// Package: shared mode type for the pad contact test chain controller.
// Assumes: nothing; pure type definitions.
package bct_pkg;

    typedef enum logic {
        MODE_FUNC  = 1'b0,
        MODE_CHAIN = 1'b1
    } bct_mode_e;

endpackage

// File: rtl/bct_mode_latch.sv
// Module: bct_mode_latch
// Captures the test-mode decision at each release of rst_n. A release is
// detected synchronously as rst_n high with its previous sample low.
// Assumes: rst_n, frame_lvl and lad0_lvl are stable around clock edges;
// por_n is a synchronous active-low power-on reset.
module bct_mode_latch
    import bct_pkg::*;
(
    input  logic      clk,
    input  logic      por_n,
    input  logic      rst_n,
    input  logic      frame_lvl,
    input  logic      lad0_lvl,
    output bct_mode_e mode
);

    logic rst_seen;
    logic release_evt;

    // Purpose: flag the cycle in which the bus reset is first seen high.
    always_comb release_evt = rst_n && !rst_seen;

    // Purpose: track the previous rst_n level and latch the mode on release.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            rst_seen <= 1'b0;
            mode     <= MODE_FUNC;
        end else begin
            rst_seen <= rst_n;
            if (release_evt) begin
                mode <= (!frame_lvl && !lad0_lvl) ? MODE_CHAIN : MODE_FUNC;
            end
        end
    end

    assert_enter_R2: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n && !rst_seen && !frame_lvl && !lad0_lvl) |=> (mode == MODE_CHAIN));

    assert_exit_R3: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n && !rst_seen && (frame_lvl || lad0_lvl)) |=> (mode == MODE_FUNC));

    assert_mode_hold_R4: assert property (@(posedge clk) disable iff (!por_n)
        !(rst_n && !rst_seen) |=> $stable(mode));

endmodule

// File: rtl/bct_xnor_chain.sv
// Module: bct_xnor_chain
// Serial cascade of two-input XNOR stages. Stage 0 is input bit 0. Each
// later stage combines the previous stage with the next input bit.
// Assumes: N_IN >= 2; purely combinational, no clock.
module bct_xnor_chain #(
    parameter int N_IN = 16
) (
    input  logic [N_IN-1:0] din,
    output logic            dout
);

    localparam int LAST = N_IN - 1;

    logic [N_IN-1:0] stage;

    // Purpose: seed the cascade with the first input.
    always_comb stage[0] = din[0];

    for (genvar g = 1; g < N_IN; g++) begin : g_stage
        // Purpose: one XNOR stage of the cascade.
        always_comb stage[g] = ~(stage[g-1] ^ din[g]);
    end

    // Purpose: the final stage result is the chain output.
    always_comb dout = stage[LAST];

endmodule

// File: rtl/bct_pad_mux.sv
// Module: bct_pad_mux
// Per-pad direction and data override. In chain mode the pad is an input
// and the core sees zero. Otherwise the pad connects straight to the core.
// Assumes: chain_mode is a registered, glitch-free level.
module bct_pad_mux #(
    parameter int N_PADS = 16
) (
    input  logic              chain_mode,
    input  logic [N_PADS-1:0] pad_in,
    input  logic [N_PADS-1:0] core_oe,
    input  logic [N_PADS-1:0] core_out,
    output logic [N_PADS-1:0] core_in,
    output logic [N_PADS-1:0] pad_oe,
    output logic [N_PADS-1:0] pad_out
);

    for (genvar p = 0; p < N_PADS; p++) begin : g_pad
        // Purpose: select functional or parked values for one pad.
        always_comb begin
            if (chain_mode) begin
                core_in[p] = 1'b0;
                pad_oe[p]  = 1'b0;
                pad_out[p] = 1'b0;
            end else begin
                core_in[p] = pad_in[p];
                pad_oe[p]  = core_oe[p];
                pad_out[p] = core_out[p];
            end
        end
    end

endmodule

// File: rtl/board_contact_chain.sv
// Module: board_contact_chain (top)
// Pad contact test controller: latches the mode at each bus reset release,
// overrides pad directions in chain mode, and puts the XNOR chain result
// onto the transmit pad.
// Assumes: FRAME_IDX and LAD0_IDX are distinct and below N_PADS; inputs
// settle away from the rising clock edge.
module board_contact_chain
    import bct_pkg::*;
#(
    parameter int N_PADS    = 16,
    parameter int FRAME_IDX = 0,
    parameter int LAD0_IDX  = 1
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic [N_PADS-1:0] pad_in,
    input  logic [N_PADS-1:0] core_oe,
    input  logic [N_PADS-1:0] core_out,
    input  logic              core_txd,
    output logic [N_PADS-1:0] core_in,
    output logic [N_PADS-1:0] pad_oe,
    output logic [N_PADS-1:0] pad_out,
    output logic              txd_pad
);

    localparam logic PARITY_FLIP = ((N_PADS - 1) % 2) == 1;

    bct_mode_e mode;
    logic      chain_mode;
    logic      chain_res;

    bct_mode_latch u_mode (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .frame_lvl (pad_in[FRAME_IDX]),
        .lad0_lvl  (pad_in[LAD0_IDX]),
        .mode      (mode)
    );

    // Purpose: decode the latched mode into a control level.
    always_comb chain_mode = (mode == MODE_CHAIN);

    bct_xnor_chain #(.N_IN(N_PADS)) u_chain (
        .din  (pad_in),
        .dout (chain_res)
    );

    bct_pad_mux #(.N_PADS(N_PADS)) u_mux (
        .chain_mode (chain_mode),
        .pad_in     (pad_in),
        .core_oe    (core_oe),
        .core_out   (core_out),
        .core_in    (core_in),
        .pad_oe     (pad_oe),
        .pad_out    (pad_out)
    );

    // Purpose: borrow the transmit pad for the chain result in chain mode.
    always_comb txd_pad = chain_mode ? chain_res : core_txd;

    assert_pads_input_R5: assert property (@(posedge clk) disable iff (!por_n)
        chain_mode |-> (pad_oe == '0 && pad_out == '0));

    assert_core_parked_R6: assert property (@(posedge clk) disable iff (!por_n)
        chain_mode |-> (core_in == '0));

    assert_chain_toggle_R7: assert property (@(posedge clk) disable iff (!por_n)
        (chain_mode && $past(chain_mode) && $countones(pad_in ^ $past(pad_in)) == 1)
        |-> (txd_pad != $past(txd_pad)));

    assert_chain_parity_R8: assert property (@(posedge clk) disable iff (!por_n)
        chain_mode |-> (txd_pad == ((^pad_in) ^ PARITY_FLIP)));

    assert_passthrough_R9: assert property (@(posedge clk) disable iff (!por_n)
        !chain_mode |-> (pad_oe == core_oe && core_in == pad_in && txd_pad == core_txd));

endmodule

// File: tb/sim_board_contact_chain.sv
// Directed bench for board_contact_chain: one task per scenario.
module sim_board_contact_chain;

    localparam int CLK_PERIOD = 10;
    localparam int N = 16;
    localparam int FI = 0;
    localparam int LI = 1;

    logic         clk = 1'b0;
    logic         por_n = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] core_oe = '0;
    logic [N-1:0] core_out = '0;
    logic         core_txd = 1'b0;
    logic [N-1:0] core_in;
    logic [N-1:0] pad_oe;
    logic [N-1:0] pad_out;
    logic         txd_pad;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    board_contact_chain #(.N_PADS(N), .FRAME_IDX(FI), .LAD0_IDX(LI)) u0 (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .pad_in(pad_in),
        .core_oe(core_oe), .core_out(core_out), .core_txd(core_txd),
        .core_in(core_in), .pad_oe(pad_oe), .pad_out(pad_out), .txd_pad(txd_pad)
    );

    function automatic logic model_chain(input logic [N-1:0] v);
        return (^v) ^ (((N - 1) % 2) == 1);
    endfunction

    task automatic chk(input logic ok, input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_chain_state(input string req);
        chk(pad_oe == '0, {req, " R5 pad_oe"}, pad_oe, '0);
        chk(pad_out == '0, {req, " R5 pad_out"}, pad_out, '0);
        chk(core_in == '0, {req, " R6 core_in"}, core_in, '0);
        chk(txd_pad == model_chain(pad_in), {req, " R8 txd"},
            {{(N-1){1'b0}}, txd_pad}, {{(N-1){1'b0}}, model_chain(pad_in)});
    endtask

    task automatic check_func_state(input string req);
        chk(pad_oe == core_oe, {req, " R9 pad_oe"}, pad_oe, core_oe);
        chk(pad_out == core_out, {req, " R9 pad_out"}, pad_out, core_out);
        chk(core_in == pad_in, {req, " R9 core_in"}, core_in, pad_in);
        chk(txd_pad == core_txd, {req, " R9 txd"},
            {{(N-1){1'b0}}, txd_pad}, {{(N-1){1'b0}}, core_txd});
    endtask

    // Pulse rst_n low, set the sampled pads, release, and settle two edges.
    task automatic do_release(input logic frame, input logic lad0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); pad_in[FI] = frame; pad_in[LI] = lad0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); @(negedge clk); #1;
    endtask

    task automatic t_power_on();
        core_oe = 16'hA5C3; core_out = 16'h0F0F; core_txd = 1'b1;
        pad_in = 16'h0000;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk); #1;
        check_func_state("R1 power-on");
    endtask

    task automatic t_enter();
        pad_in = 16'h3C5C;
        do_release(1'b0, 1'b0);
        check_chain_state("R2 enter");
    endtask

    task automatic t_walk(input logic [N-1:0] base);
        @(negedge clk); pad_in = base; pad_in[FI] = 1'b0; pad_in[LI] = 1'b0; #1;
        check_chain_state("R8 base");
        for (int i = 0; i < N; i++) begin
            logic prev;
            prev = txd_pad;
            @(negedge clk); pad_in[i] = ~pad_in[i]; #1;
            chk(txd_pad == ~prev, "R7 single-pad toggle",
                {{(N-1){1'b0}}, txd_pad}, {{(N-1){1'b0}}, ~prev});
            chk(core_in == '0, "R6 parked during walk", core_in, '0);
        end
        @(posedge clk); @(negedge clk); #1;
        check_chain_state("R4 mode held after walk");
    endtask

    task automatic t_hold_in_reset();
        @(negedge clk); rst_n = 1'b0; pad_in[FI] = 1'b1;
        repeat (3) @(negedge clk); #1;
        check_chain_state("R4 held while reset low");
        @(negedge clk); pad_in[FI] = 1'b0;
    endtask

    task automatic t_exit(input logic frame, input logic lad0, input string req);
        core_oe = 16'h1234; core_out = 16'hFEDC; core_txd = 1'b0;
        pad_in = 16'h8001;
        do_release(frame, lad0);
        check_func_state(req);
        @(negedge clk); core_txd = 1'b1; pad_in = 16'h7E00; pad_in[FI] = frame; pad_in[LI] = lad0; #1;
        check_func_state({req, " second pattern"});
    endtask

    task automatic t_no_entry_while_high();
        @(negedge clk); pad_in[FI] = 1'b0; pad_in[LI] = 1'b0;
        repeat (3) @(negedge clk); #1;
        check_func_state("R4 low pads without release");
    endtask

    initial begin
        fork
            begin
                t_power_on();
                t_enter();
                t_walk(16'h0000);
                t_walk(16'hBEEC);
                t_hold_in_reset();
                t_exit(1'b1, 1'b0, "R3 exit frame high");
                t_no_entry_while_high();
                do_release(1'b0, 1'b0);
                check_chain_state("R2 re-enter");
                t_exit(1'b0, 1'b1, "R3 exit lad0 high");
                do_release(1'b0, 1'b0);
                t_walk(16'h5550);
                t_exit(1'b1, 1'b1, "R3 exit both high");
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule